// File: doc/BRIEF.md
# ASID-Tagged LRU Translation Buffer

This block is a fully associative cache of completed two-level virtual-to-physical translations for a 32-bit virtual address space with a 34-bit physical address space. Each slot holds a virtual page number, a physical page number, an address-space tag, a global flag and a large-page flag. A large page covers 4 MiB; a small page covers 4 KiB. A lookup is answered in the same cycle it is presented. The answer gives the hit, the physical address and the flags of the matching slot.

A fill port writes in the result of a finished table walk. When every slot is in use, the fill replaces the exact least recently used slot. A flush port performs fence-style invalidation in four variants: everything, one address-space tag, one virtual page, or both together. A debug port lists the slots in recency order. It is used to inspect the buffer and to check the replacement order.

Top module: `asid_lru_tlb`

## Requirements
- R1: After reset every slot is invalid. Every lookup misses, and every debug position reports `dbg_valid` = 0.
- R2: A lookup with `lk_valid` = 1 hits only on a valid slot whose page matches. That slot must also be global or carry a tag equal to `lk_asid`. On a miss, `lk_hit`, `lk_pa`, `lk_global` and `lk_mega` are all 0.
- R3: A small-page slot compares VA[31:12] with its stored page number and returns PA = {PPN[21:0], VA[11:0]}. A large-page slot compares only VA[31:22] with the stored page number bits [19:10] and returns PA = {PPN[21:10], VA[21:0]}.
- R4: A fill that matches no slot goes to the lowest-numbered invalid slot. If no slot is invalid, it replaces the least recently used slot. The filled slot becomes the most recent.
- R5: A lookup hit makes the hit slot the most recent. Every slot that was more recent than it moves one place older. In a cycle with a fill or a flush, the lookup's recency update is dropped.
- R6: A fill matches a slot when its page and tag would hit that slot under the rules of R2 and R3. Such a fill overwrites that slot in place and makes it the most recent. No other slot changes.
- R7: A flush with both `fl_use_asid` and `fl_use_va` at 0 invalidates every slot. A flush takes effect before a lookup in the next cycle. A fill in the same cycle as a flush is dropped.
- R8: A flush with only `fl_use_asid` = 1 invalidates the non-global slots whose tag equals `fl_asid`. Global slots survive.
- R9: A flush with only `fl_use_va` = 1 invalidates every slot that maps `fl_vpn` under the comparison of R3. The tag and the global flag do not matter.
- R10: A flush with both selects at 1 invalidates only the non-global slots that map `fl_vpn` and whose tag equals `fl_asid`.
- R11: Debug position p returns the slot of recency rank p, where rank 0 is the most recent. Invalidation leaves a slot's rank unchanged, and the slot then shows `dbg_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 34 | Translated physical address |
| lk_global | output | 1 | Global flag of hit slot |
| lk_mega | output | 1 | Large-page flag of hit slot |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | 20 | Virtual page number VA[31:12] to store |
| fill_asid | input | ASID_W | Tag to store |
| fill_ppn | input | 22 | Physical page number to store |
| fill_global | input | 1 | Global flag to store |
| fill_mega | input | 1 | Large-page flag to store |
| fl_valid | input | 1 | Flush request |
| fl_use_asid | input | 1 | Restrict flush to a tag |
| fl_use_va | input | 1 | Restrict flush to a page |
| fl_asid | input | ASID_W | Tag selector for flush |
| fl_vpn | input | 20 | Page selector VA[31:12] for flush |
| dbg_pos | input | $clog2(ENTRIES) | Recency position to read |
| dbg_valid | output | 1 | Slot at position is valid |
| dbg_vpn | output | 20 | Stored virtual page number |
| dbg_ppn | output | 22 | Stored physical page number |
| dbg_asid | output | ASID_W | Stored tag |
| dbg_global | output | 1 | Stored global flag |
| dbg_mega | output | 1 | Stored large-page flag |

## Verification
A corrupted rank array does not show at the lookup port until the next fill into a full buffer. There the wrong slot gets evicted, and a later lookup misses. The debug port exposes the same fault in the same cycle, so every position is swept after each fill, flush and lookup hit. A flush that selects the wrong slots shows on the very next lookup as a stale hit or a false miss. The lookup outputs are therefore compared on every tag and address combination after each flush variant.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int VA_W       = 32;
   localparam int PG_OFS_W   = 12;
   localparam int VPN_W      = VA_W - PG_OFS_W;
   localparam int VPN_HI_W   = 10;
   localparam int BIG_OFS_W  = VA_W - VPN_HI_W;
   localparam int PPN_W      = 22;
   localparam int PA_W       = PPN_W + PG_OFS_W;
   localparam int PPN_HI_W   = PA_W - BIG_OFS_W;

   typedef struct packed {
      logic              valid;
      logic [VPN_W-1:0]  vpn;
      logic [PPN_W-1:0]  ppn;
      logic              glob;
      logic              mega;
   } tlb_map_t;
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match #(
   parameter int ASID_W = 9
) (
   input  tlb_pkg::tlb_map_t               ent,
   input  logic [ASID_W-1:0]               ent_asid,
   input  logic [tlb_pkg::VPN_W-1:0]       vpn,
   input  logic [ASID_W-1:0]               asid,
   output logic                            addr_hit,
   output logic                            asid_eq
);
   import tlb_pkg::*;
   localparam int LOW_W = VPN_W - VPN_HI_W;

   logic hi_eq;
   logic lo_eq;

   always_comb begin
      hi_eq    = ent.vpn[VPN_W-1:LOW_W] == vpn[VPN_W-1:LOW_W];
      lo_eq    = ent.vpn[LOW_W-1:0] == vpn[LOW_W-1:0];
      addr_hit = ent.valid && hi_eq && (ent.mega || lo_eq);
      asid_eq  = ent_asid == asid;
   end
endmodule

// File: rtl/tlb_lru_rank.sv
module tlb_lru_rank #(
   parameter int N  = 48,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          touch_en,
   input  logic [IW-1:0] touch_slot,
   input  logic [IW-1:0] dbg_pos,
   output logic [IW-1:0] lru_slot,
   output logic [IW-1:0] dbg_slot
);
   localparam logic [IW-1:0] OLDEST = IW'(N - 1);

   if (N < 2) begin : g_bad_n
      $error("tlb_lru_rank needs at least two slots");
   end

   logic [IW-1:0] rank_q [N];
   logic [IW-1:0] touched_rank;

   assign touched_rank = rank_q[touch_slot];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) rank_q[i] <= IW'(i);
      end else if (touch_en) begin
         for (int i = 0; i < N; i++) begin
            if (IW'(i) == touch_slot)
               rank_q[i] <= '0;
            else if (rank_q[i] < touched_rank)
               rank_q[i] <= rank_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      lru_slot = '0;
      dbg_slot = '0;
      for (int i = 0; i < N; i++) begin
         if (rank_q[i] == OLDEST)  lru_slot = IW'(i);
         if (rank_q[i] == dbg_pos) dbg_slot = IW'(i);
      end
   end
endmodule

// File: rtl/asid_lru_tlb.sv
module asid_lru_tlb #(
   parameter int ENTRIES = 48,
   parameter int ASID_W  = 9,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               lk_valid,
   input  logic [31:0]        lk_va,
   input  logic [ASID_W-1:0]  lk_asid,
   output logic               lk_hit,
   output logic [33:0]        lk_pa,
   output logic               lk_global,
   output logic               lk_mega,
   input  logic               fill_valid,
   input  logic [19:0]        fill_vpn,
   input  logic [ASID_W-1:0]  fill_asid,
   input  logic [21:0]        fill_ppn,
   input  logic               fill_global,
   input  logic               fill_mega,
   input  logic               fl_valid,
   input  logic               fl_use_asid,
   input  logic               fl_use_va,
   input  logic [ASID_W-1:0]  fl_asid,
   input  logic [19:0]        fl_vpn,
   input  logic [IW-1:0]      dbg_pos,
   output logic               dbg_valid,
   output logic [19:0]        dbg_vpn,
   output logic [21:0]        dbg_ppn,
   output logic [ASID_W-1:0]  dbg_asid,
   output logic               dbg_global,
   output logic               dbg_mega
);
   import tlb_pkg::*;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("asid_lru_tlb needs at least two entries");
   end
   if (ASID_W < 1 || ASID_W > 16) begin : g_bad_asid
      $error("asid_lru_tlb tag width out of range");
   end

   tlb_map_t          ent_q  [ENTRIES];
   logic [ASID_W-1:0] asid_q [ENTRIES];

   logic [ENTRIES-1:0] lk_addr, lk_asq;
   logic [ENTRIES-1:0] fi_addr, fi_asq;
   logic [ENTRIES-1:0] fl_addr, fl_asq;
   logic [ENTRIES-1:0] kill_vec;
   logic [ENTRIES-1:0] valid_vec;

   logic          lk_found, dup_found, free_found;
   logic [IW-1:0] lk_idx, dup_idx, free_idx, fill_tgt;
   logic [IW-1:0] lru_slot, dbg_slot;
   logic          touch_en;
   logic [IW-1:0] touch_slot;
   tlb_map_t      lk_sel, dbg_sel, fill_ent;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      tlb_entry_match #(.ASID_W(ASID_W)) u_lk_match (
         .ent(ent_q[g]), .ent_asid(asid_q[g]), .vpn(lk_va[31:12]),
         .asid(lk_asid), .addr_hit(lk_addr[g]), .asid_eq(lk_asq[g]));
      tlb_entry_match #(.ASID_W(ASID_W)) u_fill_match (
         .ent(ent_q[g]), .ent_asid(asid_q[g]), .vpn(fill_vpn),
         .asid(fill_asid), .addr_hit(fi_addr[g]), .asid_eq(fi_asq[g]));
      tlb_entry_match #(.ASID_W(ASID_W)) u_flush_match (
         .ent(ent_q[g]), .ent_asid(asid_q[g]), .vpn(fl_vpn),
         .asid(fl_asid), .addr_hit(fl_addr[g]), .asid_eq(fl_asq[g]));
      assign valid_vec[g] = ent_q[g].valid;
   end

   always_comb begin
      lk_found   = 1'b0;
      lk_idx     = '0;
      dup_found  = 1'b0;
      dup_idx    = '0;
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (lk_addr[i] && (ent_q[i].glob || lk_asq[i])) begin
            lk_found = 1'b1;
            lk_idx   = IW'(i);
         end
         if (fi_addr[i] && (ent_q[i].glob || fi_asq[i])) begin
            dup_found = 1'b1;
            dup_idx   = IW'(i);
         end
         if (!ent_q[i].valid) begin
            free_found = 1'b1;
            free_idx   = IW'(i);
         end
      end
   end

   always_comb begin
      if (dup_found)       fill_tgt = dup_idx;
      else if (free_found) fill_tgt = free_idx;
      else                 fill_tgt = lru_slot;
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         case ({fl_use_asid, fl_use_va})
            2'b00:   kill_vec[i] = ent_q[i].valid;
            2'b10:   kill_vec[i] = ent_q[i].valid && !ent_q[i].glob && fl_asq[i];
            2'b01:   kill_vec[i] = fl_addr[i];
            default: kill_vec[i] = fl_addr[i] && !ent_q[i].glob && fl_asq[i];
         endcase
      end
   end

   always_comb begin
      fill_ent.valid = 1'b1;
      fill_ent.vpn   = fill_vpn;
      fill_ent.ppn   = fill_ppn;
      fill_ent.glob  = fill_global;
      fill_ent.mega  = fill_mega;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < ENTRIES; i++) begin
            ent_q[i]  <= '0;
            asid_q[i] <= '0;
         end
      end else if (fl_valid) begin
         for (int i = 0; i < ENTRIES; i++)
            if (kill_vec[i]) ent_q[i].valid <= 1'b0;
      end else if (fill_valid) begin
         ent_q[fill_tgt]  <= fill_ent;
         asid_q[fill_tgt] <= fill_asid;
      end
   end

   assign touch_en   = !fl_valid && (fill_valid || lk_hit);
   assign touch_slot = fill_valid ? fill_tgt : lk_idx;

   tlb_lru_rank #(.N(ENTRIES), .IW(IW)) u_rank (
      .clk(clk), .rst(rst), .touch_en(touch_en), .touch_slot(touch_slot),
      .dbg_pos(dbg_pos), .lru_slot(lru_slot), .dbg_slot(dbg_slot));

   always_comb begin
      lk_sel    = ent_q[lk_idx];
      lk_hit    = lk_valid && lk_found;
      lk_pa     = '0;
      lk_global = 1'b0;
      lk_mega   = 1'b0;
      if (lk_hit) begin
         lk_global = lk_sel.glob;
         lk_mega   = lk_sel.mega;
         if (lk_sel.mega)
            lk_pa = {lk_sel.ppn[PPN_W-1:PPN_W-PPN_HI_W], lk_va[BIG_OFS_W-1:0]};
         else
            lk_pa = {lk_sel.ppn, lk_va[PG_OFS_W-1:0]};
      end
   end

   always_comb begin
      dbg_sel    = ent_q[dbg_slot];
      dbg_valid  = dbg_sel.valid;
      dbg_vpn    = dbg_sel.vpn;
      dbg_ppn    = dbg_sel.ppn;
      dbg_asid   = asid_q[dbg_slot];
      dbg_global = dbg_sel.glob;
      dbg_mega   = dbg_sel.mega;
   end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
   parameter int N = 48
) (
   input logic         clk,
   input logic         rst,
   input logic         lk_hit,
   input logic [31:0]  lk_va,
   input logic [33:0]  lk_pa,
   input logic         lk_mega,
   input logic         fl_valid,
   input logic         fl_use_asid,
   input logic         fl_use_va,
   input logic [N-1:0] valid_vec
);
   a_r1_reset_empties: assert property (@(posedge clk)
      rst |=> (valid_vec == '0));

   a_r7_flush_all_misses: assert property (@(posedge clk) disable iff (rst)
      (fl_valid && !fl_use_asid && !fl_use_va) |=> !lk_hit);

   a_r3_small_offset: assert property (@(posedge clk) disable iff (rst)
      (lk_hit && !lk_mega) |-> (lk_pa[11:0] == lk_va[11:0]));

   a_r3_big_offset: assert property (@(posedge clk) disable iff (rst)
      (lk_hit && lk_mega) |-> (lk_pa[21:0] == lk_va[21:0]));

   a_r4_fill_adds_one: assert property (@(posedge clk) disable iff (rst)
      !fl_valid |=> ($countones(valid_vec) <= $past($countones(valid_vec)) + 1));

   a_r8_flush_never_grows: assert property (@(posedge clk) disable iff (rst)
      fl_valid |=> ($countones(valid_vec) <= $past($countones(valid_vec))));
endmodule

bind asid_lru_tlb tlb_checker #(.N(ENTRIES)) u_chk (
   .clk(clk), .rst(rst), .lk_hit(lk_hit), .lk_va(lk_va), .lk_pa(lk_pa),
   .lk_mega(lk_mega), .fl_valid(fl_valid), .fl_use_asid(fl_use_asid),
   .fl_use_va(fl_use_va), .valid_vec(valid_vec));

// File: tb/asid_lru_tlb_bench.sv
`timescale 1ns/1ps
module asid_lru_tlb_bench;
   localparam int N  = 4;
   localparam int AW = 9;
   localparam int IW = 2;

   logic clk = 0;
   logic rst = 1;
   always #2.5 clk = ~clk;

   logic lk_valid = 0; logic [31:0] lk_va = 0; logic [AW-1:0] lk_asid = 0;
   logic lk_hit, lk_global, lk_mega; logic [33:0] lk_pa;
   logic fill_valid = 0; logic [19:0] fill_vpn = 0; logic [AW-1:0] fill_asid = 0;
   logic [21:0] fill_ppn = 0; logic fill_global = 0, fill_mega = 0;
   logic fl_valid = 0, fl_use_asid = 0, fl_use_va = 0;
   logic [AW-1:0] fl_asid = 0; logic [19:0] fl_vpn = 0;
   logic [IW-1:0] dbg_pos = 0;
   logic dbg_valid, dbg_global, dbg_mega; logic [19:0] dbg_vpn;
   logic [21:0] dbg_ppn; logic [AW-1:0] dbg_asid;

   asid_lru_tlb #(.ENTRIES(N), .ASID_W(AW)) u_asid_lru_tlb (.*);

   int n_chk = 0, n_fail = 0;
   bit m_v [N]; bit m_g [N]; bit m_m [N];
   logic [19:0] m_vpn [N]; logic [21:0] m_ppn [N]; logic [AW-1:0] m_as [N];
   int m_rank [N];

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit m_addr(int i, logic [19:0] vpn);
      return m_v[i] && (m_m[i] ? m_vpn[i][19:10] == vpn[19:10] : m_vpn[i] == vpn);
   endfunction

   function automatic int m_find(logic [19:0] vpn, logic [AW-1:0] asid);
      for (int i = 0; i < N; i++)
         if (m_addr(i, vpn) && (m_g[i] || m_as[i] == asid)) return i;
      return -1;
   endfunction

   task automatic m_touch(int s);
      int old = m_rank[s];
      for (int i = 0; i < N; i++) if (m_rank[i] < old) m_rank[i]++;
      m_rank[s] = 0;
   endtask

   task automatic do_fill(string req, logic [31:0] va, logic [AW-1:0] asid,
                          logic [21:0] ppn, bit g, bit m);
      int s;
      fill_valid = 1; fill_vpn = va[31:12]; fill_asid = asid;
      fill_ppn = ppn; fill_global = g; fill_mega = m;
      @(posedge clk);
      s = m_find(va[31:12], asid);
      if (s < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) s = i;
      if (s < 0) for (int i = 0; i < N; i++) if (m_rank[i] == N - 1) s = i;
      m_v[s] = 1; m_vpn[s] = va[31:12]; m_ppn[s] = ppn; m_as[s] = asid;
      m_g[s] = g; m_m[s] = m;
      m_touch(s);
      @(negedge clk);
      fill_valid = 0;
      if (req != "") sweep(req);
   endtask

   task automatic do_flush(string req, bit ua, bit uv, logic [AW-1:0] asid, logic [31:0] va);
      fl_valid = 1; fl_use_asid = ua; fl_use_va = uv; fl_asid = asid; fl_vpn = va[31:12];
      @(posedge clk);
      for (int i = 0; i < N; i++) begin
         bit k;
         case ({ua, uv})
            2'b00:   k = m_v[i];
            2'b10:   k = m_v[i] && !m_g[i] && m_as[i] == asid;
            2'b01:   k = m_addr(i, va[31:12]);
            default: k = m_addr(i, va[31:12]) && !m_g[i] && m_as[i] == asid;
         endcase
         if (k) m_v[i] = 0;
      end
      @(negedge clk);
      fl_valid = 0;
      sweep(req);
   endtask

   task automatic look(string req, logic [31:0] va, logic [AW-1:0] asid);
      int s;
      logic [36:0] exp;
      lk_valid = 1; lk_va = va; lk_asid = asid;
      #1;
      s = m_find(va[31:12], asid);
      exp = '0;
      if (s >= 0)
         exp = {1'b1, m_g[s], m_m[s],
                m_m[s] ? {m_ppn[s][21:10], va[21:0]} : {m_ppn[s], va[11:0]}};
      chk(req, $sformatf("lookup va=%h asid=%0d", va, asid),
          64'({lk_hit, lk_global, lk_mega, lk_pa}), 64'(exp));
      @(posedge clk);
      if (s >= 0) m_touch(s);
      @(negedge clk);
      lk_valid = 0;
   endtask

   task automatic sweep(string req);
      for (int p = 0; p < N; p++) begin
         int s = 0;
         logic [63:0] act, exp;
         dbg_pos = IW'(p);
         #0.4;
         for (int i = 0; i < N; i++) if (m_rank[i] == p) s = i;
         exp = m_v[s] ? 64'({1'b1, m_vpn[s], m_ppn[s], m_as[s], m_g[s], m_m[s]}) : 64'(0);
         act = dbg_valid ? 64'({1'b1, dbg_vpn, dbg_ppn, dbg_asid, dbg_global, dbg_mega}) : 64'(0);
         chk(req, $sformatf("R11 debug position %0d", p), act, exp);
      end
   endtask

   task automatic look_grid(string req);
      logic [31:0] vas [8] = '{32'hB0000000, 32'hB0002ABC, 32'hB0001000, 32'h80000000,
                               32'h803FFFFC, 32'h80400000, 32'h12345678, 32'hC0000004};
      for (int a = 0; a < 4; a++)
         for (int v = 0; v < 8; v++) look(req, vas[v], AW'(a));
      sweep(req);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_v[i] = 0; m_rank[i] = i; m_g[i] = 0; m_m[i] = 0;
         m_vpn[i] = 0; m_ppn[i] = 0; m_as[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      // R1: empty after reset
      sweep("R1");
      look("R1", 32'hB0000000, 0);
      // R4: fills land in free slots in order
      do_fill("R4", 32'hB0000000, 1, 22'h0C0000, 0, 0);
      do_fill("R4", 32'hB0002000, 1, 22'h0C0000, 0, 0);
      do_fill("R4", 32'h80000000, 0, 22'h080000, 1, 1);
      do_fill("R4", 32'hB0000000, 2, 22'h123456, 0, 0);
      // R2 R3 R5: matching, sizes, recency
      look("R2", 32'hB0000123, 1);
      look("R2", 32'hB0000123, 3);
      look("R2", 32'hB0000FFF, 2);
      look("R3", 32'h803ABCDE, 5);
      look("R3", 32'h80400000, 5);
      sweep("R5");
      // R4: full buffer evicts least recent
      do_fill("R4", 32'hC0000000, 7, 22'h3FFFFF, 0, 0);
      do_fill("R4", 32'hC0001000, 7, 22'h2AAAAA, 0, 0);
      look_grid("R2");
      // R6: duplicate overwrites in place
      do_fill("R6", 32'hC0000000, 7, 22'h111111, 0, 0);
      look("R6", 32'hC0000004, 7);
      sweep("R6");
      // R8: flush by tag keeps global
      do_fill("", 32'h80000000, 0, 22'h080000, 1, 1);
      do_fill("", 32'hB0000000, 1, 22'h0C0000, 0, 0);
      do_flush("R8", 1, 0, 7, 0);
      look_grid("R8");
      do_flush("R8", 1, 0, 0, 0);
      look("R8", 32'h80001234, 3);
      // R9: flush by address removes global and every tag
      do_fill("", 32'hB0000000, 2, 22'h000777, 0, 0);
      do_flush("R9", 0, 1, 0, 32'h80123000);
      look_grid("R9");
      do_flush("R9", 0, 1, 9, 32'hB0000000);
      look_grid("R9");
      // R10: flush by both
      do_fill("", 32'hB0000000, 1, 22'h0C0000, 0, 0);
      do_fill("", 32'hB0000000, 2, 22'h0C0001, 0, 0);
      do_fill("", 32'hB0000000, 3, 22'h0C0002, 1, 0);
      do_flush("R10", 1, 1, 2, 32'hB0000000);
      look_grid("R10");
      do_flush("R10", 1, 1, 3, 32'hB0000000);
      look("R10", 32'hB0000010, 3);
      // R7: flush all; fill in the same cycle is dropped
      fill_valid = 1; fill_vpn = 20'h55555; fill_asid = 1; fill_ppn = 22'h1; 
      fill_global = 1; fill_mega = 0;
      do_flush("R7", 0, 0, 0, 0);
      fill_valid = 0;
      look("R7", 32'h55555000, 1);
      look_grid("R7");
      sweep("R1");
      finish_run();
   end
endmodule